// File: doc/BRIEF.md
# Masked Multi-CPU Device Interrupt Router

This block gathers level-style interrupt sources from devices into one shared pending vector and fans that vector out to several processors. Each processor owns an enable mask. The router keeps a per-processor routed vector, which is the mask ANDed with the pending vector. It raises a device-interrupt request line for every processor whose routed vector is not empty.

Devices drive one post strobe and one clear strobe per source. Software reaches the pending vector, the masks and the routed vectors through a register port that accepts one request per cycle. Every request is answered exactly one cycle later with a response flag, read data and an error bit. Accesses that are not allowed are refused with the error bit and change nothing.

A clear strobe that hits a source whose pending bit is already zero is not an error. It is flagged on a one-cycle spurious-clear pulse.

Top module: `dev_irq_router`

## Requirements
- R1: A post strobe on source n sets pending bit n and a clear strobe resets it. When both strobes hit the same source in one cycle, the post wins. The new pending value applies from the next clock edge.
- R2: For each CPU k, the routed vector on `routed_o[k*NUM_SRC +: NUM_SRC]` equals mask k AND the pending vector at all times after reset. Both are updated at the same clock edge.
- R3: The routed vectors are recomputed at the edge of every mask write, source post and source clear. A mask write and a post in the same cycle both take effect, and routing uses the new mask with the new pending vector.
- R4: `irq_o[k]` is high exactly while routed vector k has at least one bit set. It drops at the edge where a mask write or a source clear empties that vector.
- R5: A clear strobe on a source whose pending bit is zero (and that is not posted in the same cycle) changes no state. It raises `spur_o` for one cycle, at the edge that follows.
- R6: The register index is `req_addr_i[ADDR_W-1:6]`, which gives a 64-byte stride; the low six bits are ignored. Index 0 is the pending vector, index 4+k is the mask of CPU k and index 8+k is the routed vector of CPU k. Values are returned zero-extended to 64 bits.
- R7: `req_size_i` encodes the access width: 3 = 64-bit, 2 = 32-bit, 1 = 16-bit, 0 = 8-bit. Only 64-bit accesses are legal, except a 32-bit read of the pending vector, which returns its low 32 bits with the upper 32 bits zero.
- R8: A write to the pending vector or to a routed vector is refused with `rsp_err_o` high and changes no state.
- R9: An access with an illegal size or to an unmapped index is answered with `rsp_err_o` high and `rsp_rdata_o` zero, and changes no state.
- R10: After reset the pending bits, masks and routed vectors are zero, every request line is low, and `rsp_valid_o` and `spur_o` are low.
- R11: Every request held on `req_valid_i` at a clock edge is answered one cycle later with `rsp_valid_o` high. Read data shows the register as it was before any update made at that same edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_post_i | input | NUM_SRC | Per-source post strobes |
| src_clr_i | input | NUM_SRC | Per-source clear strobes |
| req_valid_i | input | 1 | Register request present (always accepted) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access width code (see R7) |
| req_addr_i | input | ADDR_W | Byte offset from block base |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_err_o | output | 1 | Access refused |
| rsp_rdata_o | output | 64 | Read data |
| routed_o | output | NUM_CPU*NUM_SRC | Routed vectors, CPU k in slice k |
| irq_o | output | NUM_CPU | Device-interrupt request per CPU |
| spur_o | output | 1 | Spurious clear seen in the previous cycle |

## Verification
The bench builds the router with its defaults: 64 sources, four CPUs and a 10-bit offset. With these values every mapped index and every unmapped index from 0 to 15 can be reached through the address field. Bit 63 and bits above 31 of the pending vector are present, so the 32-bit read truncation is visible. Directed cases cover the same-cycle mask write with post, post-against-clear on one source, and the spurious clear. The random phase then mixes sparse strobes with host requests of random width and index against a bench model of the pending vector and the masks.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
    localparam int DATA_W    = 64;
    localparam int OFF_SHIFT = 6;
    localparam int IDX_PEND  = 0;
    localparam int IDX_MASK0 = 4;
    localparam int IDX_ROUT0 = 8;

    typedef enum logic [1:0] {
        ACC_8  = 2'd0,
        ACC_16 = 2'd1,
        ACC_32 = 2'd2,
        ACC_64 = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2,
        SEL_ROUT = 2'd3
    } sel_e;
endpackage

// File: rtl/irq_rt_decode.sv
module irq_rt_decode
    import irq_rt_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 10,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              write_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    output sel_e              sel_o,
    output logic [CPU_W-1:0]  cpu_o,
    output logic              legal_o,
    output logic              half_o
);
    int idx;

    always_comb begin
        idx     = int'(addr_i[ADDR_W-1:OFF_SHIFT]);
        sel_o   = SEL_NONE;
        cpu_o   = '0;
        legal_o = 1'b0;
        half_o  = 1'b0;
        if (idx == IDX_PEND) begin
            sel_o = SEL_PEND;
            if (!write_i && size_i == ACC_64) begin
                legal_o = 1'b1;
            end else if (!write_i && size_i == ACC_32) begin
                legal_o = 1'b1;
                half_o  = 1'b1;
            end
        end
        for (int k = 0; k < NUM_CPU; k++) begin
            if (idx == IDX_MASK0 + k) begin
                sel_o   = SEL_MASK;
                cpu_o   = CPU_W'(k);
                legal_o = (size_i == ACC_64);
            end
            if (idx == IDX_ROUT0 + k) begin
                sel_o   = SEL_ROUT;
                cpu_o   = CPU_W'(k);
                legal_o = (size_i == ACC_64) && !write_i;
            end
        end
    end
endmodule

// File: rtl/irq_rt_pend.sv
module irq_rt_pend #(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] post_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               spur_o
);
    always_comb begin
        pend_o = (pend_i & ~clr_i) | post_i;
        spur_o = |(clr_i & ~pend_i & ~post_i);
    end
endmodule

// File: rtl/irq_rt_steer.sv
module irq_rt_steer #(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0]              pend_i,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0] routed_o,
    output logic [NUM_CPU-1:0]              any_o
);
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        assign routed_o[g] = mask_i[g] & pend_i;
        assign any_o[g]    = |routed_o[g];
    end
endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
    import irq_rt_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_post_i,
    input  logic [NUM_SRC-1:0]         src_clr_i,
    input  logic                       req_valid_i,
    input  logic                       req_write_i,
    input  logic [1:0]                 req_size_i,
    input  logic [ADDR_W-1:0]          req_addr_i,
    input  logic [63:0]                req_wdata_i,
    output logic                       rsp_valid_o,
    output logic                       rsp_err_o,
    output logic [63:0]                rsp_rdata_o,
    output logic [NUM_CPU*NUM_SRC-1:0] routed_o,
    output logic [NUM_CPU-1:0]         irq_o,
    output logic                       spur_o
);
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0]              pend;
        logic [NUM_CPU-1:0][NUM_SRC-1:0] mask;
        logic [NUM_CPU-1:0][NUM_SRC-1:0] rout;
        logic [NUM_CPU-1:0]              irq;
        logic                            spur;
        logic                            rsp_v;
        logic                            rsp_e;
        logic [DATA_W-1:0]               rdata;
    } state_t;

    state_t state_d, state_q;

    sel_e             sel;
    logic [CPU_W-1:0] sel_cpu;
    logic             legal;
    logic             half;
    logic             mask_wr;

    logic [NUM_SRC-1:0]              pend_nx;
    logic                            spur_nx;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_nx;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] rout_nx;
    logic [NUM_CPU-1:0]              any_nx;

    logic [NUM_SRC-1:0]              pend_vis;
    logic [NUM_CPU*NUM_SRC-1:0]      mask_vis;

    irq_rt_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
        .write_i (req_write_i),
        .size_i  (req_size_i),
        .addr_i  (req_addr_i),
        .sel_o   (sel),
        .cpu_o   (sel_cpu),
        .legal_o (legal),
        .half_o  (half)
    );

    irq_rt_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .pend_i (state_q.pend),
        .post_i (src_post_i),
        .clr_i  (src_clr_i),
        .pend_o (pend_nx),
        .spur_o (spur_nx)
    );

    assign mask_wr = req_valid_i && req_write_i && legal && (sel == SEL_MASK);

    always_comb begin
        mask_nx = state_q.mask;
        if (mask_wr) begin
            mask_nx[sel_cpu] = req_wdata_i[NUM_SRC-1:0];
        end
    end

    irq_rt_steer #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_steer (
        .mask_i   (mask_nx),
        .pend_i   (pend_nx),
        .routed_o (rout_nx),
        .any_o    (any_nx)
    );

    always_comb begin
        logic [DATA_W-1:0] pend_ext;
        state_d       = state_q;
        pend_ext      = DATA_W'(state_q.pend);
        state_d.pend  = pend_nx;
        state_d.mask  = mask_nx;
        state_d.rout  = rout_nx;
        state_d.irq   = any_nx;
        state_d.spur  = spur_nx;
        state_d.rsp_v = req_valid_i;
        state_d.rsp_e = req_valid_i && !legal;
        state_d.rdata = '0;
        if (req_valid_i && legal && !req_write_i) begin
            unique case (sel)
                SEL_PEND: state_d.rdata = half ? {32'd0, pend_ext[31:0]} : pend_ext;
                SEL_MASK: state_d.rdata = DATA_W'(state_q.mask[sel_cpu]);
                SEL_ROUT: state_d.rdata = DATA_W'(state_q.rout[sel_cpu]);
                default:  state_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_vis    = state_q.pend;
    assign mask_vis    = state_q.mask;
    assign rsp_valid_o = state_q.rsp_v;
    assign rsp_err_o   = state_q.rsp_e;
    assign rsp_rdata_o = state_q.rdata;
    assign routed_o    = state_q.rout;
    assign irq_o       = state_q.irq;
    assign spur_o      = state_q.spur;
endmodule

// File: rtl/dev_irq_router_chk.sv
module dev_irq_router_chk #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SRC-1:0]         src_post,
    input logic [NUM_SRC-1:0]         src_clr,
    input logic [NUM_SRC-1:0]         pend,
    input logic [NUM_CPU*NUM_SRC-1:0] mask,
    input logic [NUM_CPU*NUM_SRC-1:0] routed,
    input logic [NUM_CPU-1:0]         irq,
    input logic                       rsp_err
);
    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
        AST_ROUTED_IS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            routed[k*NUM_SRC +: NUM_SRC] == (mask[k*NUM_SRC +: NUM_SRC] & pend)); // R2
        AST_IRQ_TRACKS_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
            irq[k] == (|routed[k*NUM_SRC +: NUM_SRC])); // R4
    end

    AST_POST_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_post) |=> ((pend & $past(src_post)) == $past(src_post))); // R1
    AST_CLEAR_RESETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_clr & ~src_post)) |=> ((pend & $past(src_clr & ~src_post)) == '0)); // R1
    AST_ERROR_KEEPS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (mask == $past(mask))); // R9
endmodule

bind dev_irq_router dev_irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_post (src_post_i),
    .src_clr  (src_clr_i),
    .pend     (pend_vis),
    .mask     (mask_vis),
    .routed   (routed_o),
    .irq      (irq_o),
    .rsp_err  (rsp_err_o)
);

// File: tb/dev_irq_router_test.sv
`timescale 1ns/1ps
module dev_irq_router_test;
    localparam int NS = 64;
    localparam int NC = 4;
    localparam int AW = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     post = '0;
    logic [NS-1:0]     clr = '0;
    logic              rv = 1'b0;
    logic              rw = 1'b0;
    logic [1:0]        rsz = 2'd3;
    logic [AW-1:0]     raddr = '0;
    logic [63:0]       rwd = '0;
    logic              rsp_valid, rsp_err, spur;
    logic [63:0]       rsp_rdata;
    logic [NC*NS-1:0]  routed;
    logic [NC-1:0]     irq;

    int n_run = 0;
    int n_fail = 0;

    logic [63:0] m_pend;
    logic [63:0] m_mask [NC];

    always #4 clk = ~clk;

    dev_irq_router #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .src_post_i(post), .src_clr_i(clr),
        .req_valid_i(rv), .req_write_i(rw), .req_size_i(rsz), .req_addr_i(raddr),
        .req_wdata_i(rwd), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
        .rsp_rdata_o(rsp_rdata), .routed_o(routed), .irq_o(irq), .spur_o(spur)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bench model of the register port: index, size and direction rules (R6 R7 R8 R9)
    function automatic void model_acc(input bit w, input logic [AW-1:0] a, input logic [1:0] sz,
                                      output bit err, output logic [63:0] data);
        int idx;
        idx  = int'(a >> 6);
        err  = 1'b1;
        data = '0;
        if (idx == 0 && !w && sz == 2'd3) begin
            err = 0; data = m_pend;
        end else if (idx == 0 && !w && sz == 2'd2) begin
            err = 0; data = {32'd0, m_pend[31:0]};
        end else if (idx >= 4 && idx < 4 + NC && sz == 2'd3) begin
            err = 0; data = w ? 64'd0 : m_mask[idx-4];
        end else if (idx >= 8 && idx < 8 + NC && sz == 2'd3 && !w) begin
            err = 0; data = m_mask[idx-8] & m_pend;
        end
    endfunction

    task automatic step(input logic [63:0] p, input logic [63:0] c, input bit v, input bit w,
                        input logic [AW-1:0] a, input logic [1:0] sz, input logic [63:0] wd,
                        input string tag);
        bit e_err;
        logic [63:0] e_data;
        bit e_spur;
        logic [NC*NS-1:0] e_rout;
        logic [NC-1:0] e_irq;
        @(negedge clk);
        post = p; clr = c; rv = v; rw = w; raddr = a; rsz = sz; rwd = wd;
        model_acc(w, a, sz, e_err, e_data);
        e_spur = |(c & ~m_pend & ~p);
        if (v && w && !e_err) m_mask[int'(a >> 6) - 4] = wd;
        m_pend = (m_pend & ~c) | p;
        for (int k = 0; k < NC; k++) begin
            e_rout[k*NS +: NS] = m_mask[k] & m_pend;
            e_irq[k] = |(m_mask[k] & m_pend);
        end
        @(posedge clk);
        #2;
        chk(rsp_valid == v, "R11", {tag, " rsp_valid"}, 256'(rsp_valid), 256'(v));
        if (v) begin
            chk(rsp_err == e_err, e_err ? "R9" : "R11", {tag, " rsp_err"}, 256'(rsp_err), 256'(e_err));
            if (!w) chk(rsp_rdata == (e_err ? 64'd0 : e_data), "R6", {tag, " rdata"},
                        256'(rsp_rdata), 256'(e_err ? 64'd0 : e_data));
        end
        chk(spur == e_spur, "R5", {tag, " spur"}, 256'(spur), 256'(e_spur));
        chk(routed == e_rout, "R2", {tag, " routed"}, 256'(routed), 256'(e_rout));
        chk(irq == e_irq, "R4", {tag, " irq"}, 256'(irq), 256'(e_irq));
    endtask

    task automatic idle(input string tag);
        step('0, '0, 1'b0, 1'b0, '0, 2'd3, '0, tag);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_pend = '0;
        for (int k = 0; k < NC; k++) m_mask[k] = '0;
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        chk(routed == '0, "R10", "reset routed", 256'(routed), 256'd0);
        chk(irq == '0, "R10", "reset irq", 256'(irq), 256'd0);
        chk(rsp_valid == 1'b0 && spur == 1'b0, "R10", "reset rsp/spur",
            256'({rsp_valid, spur}), 256'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R10 idle");

        // R6 R2 R4: mask writes then a post
        step('0, '0, 1, 1, 10'(4 * 64), 2'd3, 64'h20, "R6 mask0");
        step('0, '0, 1, 1, 10'(5 * 64 + 13), 2'd3, '1, "R6 mask1 low bits ignored");
        step(64'h20, '0, 0, 0, '0, 2'd3, '0, "R2 post5");
        // R3: same-cycle post and mask write
        step(64'h200, '0, 1, 1, 10'(6 * 64), 2'd3, 64'h200, "R3 post9 with mask2");
        step(64'h8000_0100_0000_0008, '0, 0, 0, '0, 2'd3, '0, "R1 post 3 40 63");
        // R7: 32-bit and 64-bit pending reads
        step('0, '0, 1, 0, 10'd0, 2'd2, '0, "R7 half read");
        step('0, '0, 1, 0, 10'd0, 2'd3, '0, "R7 full read");
        step('0, '0, 1, 0, 10'(4 * 64), 2'd2, '0, "R7 half read of mask");
        // R8: writes to read-only registers
        step('0, '0, 1, 1, 10'd0, 2'd3, '1, "R8 write pending");
        step('0, '0, 1, 1, 10'(9 * 64), 2'd3, '1, "R8 write routed1");
        // R9: unmapped index and bad size
        step('0, '0, 1, 0, 10'(1 * 64), 2'd3, '0, "R9 unmapped read");
        step('0, '0, 1, 1, 10'(15 * 64), 2'd3, '1, "R9 unmapped write");
        step('0, '0, 1, 1, 10'(7 * 64), 2'd1, '1, "R9 16-bit mask write");
        // R5: spurious clear
        step('0, 64'h1000_0000_0000_0000, 0, 0, '0, 2'd3, '0, "R5 spurious clear");
        // R1: post and clear on the same source
        step(64'h2, 64'h2, 0, 0, '0, 2'd3, '0, "R1 post beats clear");
        // R4: clear drops request of CPU0
        step('0, 64'h20, 1, 0, 10'(8 * 64), 2'd3, '0, "R4 clear5, read routed0");
        step('0, '0, 1, 1, 10'(6 * 64), 2'd3, '0, "R4 mask2 cleared");
        idle("R11 idle");

        // Random phase
        for (int i = 0; i < 1500; i++) begin
            logic [63:0] p, c, wd;
            logic [AW-1:0] a;
            logic [1:0] sz;
            bit v, w;
            p  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            c  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            v  = ($urandom % 3) != 0;
            w  = ($urandom % 2) != 0;
            a  = AW'($urandom);
            if (($urandom % 2) == 0) a = AW'((($urandom % 2 == 0 ? 4 : 8) + $urandom % NC) * 64);
            sz = (($urandom % 5) == 0) ? 2'($urandom) : 2'd3;
            wd = {$urandom, $urandom} & {$urandom, $urandom};
            step(p, c, v, w, a, sz, wd, "R3 random");
        end
        idle("R3 final");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule